// File: doc/BRIEF.md
# Eight-Bit Multi-Mode Right Shifter Built From Four-Bit Slices

This block shifts an 8-bit word toward its low-order end by 0 to 7 places and registers the result. Three fill policies are available. Logical mode shifts in zeros. Arithmetic mode copies the sign bit into the vacated positions. Rotate mode sends the bits that leave the low end back in at the high end.

The datapath is made of identical four-bit slices. Each slice is a four-way selector that moves its window by 0 to 3 places. Two banks of slices share the output lines. The second bank is wired four positions further along the extended word, so it covers shifts of 4 to 7. The upper bit of the shift amount drives the active-low enables of the slices, which means that exactly one bank drives the shared lines at any time. The merged word is captured in an output register that is cleared by a synchronous, active-high reset.

Top module: `wshift_top`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `dout` becomes 0 at that edge.
- R2: `dout` shows the result for the `din`, `amt` and `mode` values sampled at the previous rising edge. A shift amount of 0 returns `din` unchanged in every mode.
- R3: When `amt[2]` is 0, only the first bank (shifts 0 to 3) drives the shared lines. When `amt[2]` is 1, only the second bank (shifts 4 to 7) drives them. Shifts of 4 to 7 give the same result as the reference model.
- R4: The shift moves bits toward the low-order end: `dout[j] = din[j+amt]` whenever `j+amt` is 7 or less.
- R5: With `mode` = 2'b00 (logical), the `amt` vacated positions at the top of `dout` are 0.
- R6: With `mode` = 2'b01 (arithmetic), the vacated positions at the top of `dout` equal `din[7]`.
- R7: With `mode` = 2'b10 (rotate), `dout[j] = din[(j+amt) mod 8]` for all j.
- R8: `mode` = 2'b11 gives the same result as logical mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| din | input | 8 | Word to be shifted |
| amt | input | 3 | Shift amount, 0 to 7 places toward bit 0 |
| mode | input | 2 | Fill policy: 00 logical, 01 arithmetic, 10 rotate, 11 logical |
| dout | output | 8 | Registered shifted word |

## Verification
The data path from the inputs to the output register is combinational, so each result is due one rising edge after its inputs are presented. The bench changes the inputs on a falling edge and reads `dout` at the next falling edge, which is half a cycle after the capturing edge. Reset is handled the same way: the bench asserts `rst` and checks for a zero output at the falling edge that follows. No comparison is made within the same half-cycle in which the inputs change.

// File: rtl/wsh_pkg.sv
package wsh_pkg;
  typedef enum logic [1:0] {
    FILL_ZERO = 2'b00,
    FILL_SIGN = 2'b01,
    FILL_ROT  = 2'b10,
    FILL_ALT  = 2'b11
  } fill_e;
endpackage

// File: rtl/wsh_fill.sv
// Builds the extended word: the data in the low bits, fill bits above it.
module wsh_fill #(
  parameter int W  = 8,
  parameter int XW = 7
) (
  input  logic [W-1:0]     d,
  input  wsh_pkg::fill_e   mode,
  output logic [W+XW-1:0]  ext
);
  assign ext[W-1:0] = d;

  for (genvar i = 0; i < XW; i++) begin : g_fill
    always_comb begin
      case (mode)
        wsh_pkg::FILL_SIGN: ext[W+i] = d[W-1];
        wsh_pkg::FILL_ROT:  ext[W+i] = d[i % W];
        default:            ext[W+i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/wsh_slice.sv
// One slice: each output picks a window bit offset by sel. Gated by an active-low enable.
module wsh_slice #(
  parameter int SW   = 4,
  parameter int SELW = 2
) (
  input  logic [2*SW-2:0] win,
  input  logic [SELW-1:0] sel,
  input  logic            en_n,
  output logic [SW-1:0]   o,
  output logic            drv
);
  assign drv = ~en_n;

  always_comb begin
    for (int n = 0; n < SW; n++) begin
      o[n] = en_n ? 1'b0 : win[n + int'(sel)];
    end
  end
endmodule

// File: rtl/wsh_bank_dec.sv
// Turns the upper shift bits into one active-low enable per bank.
module wsh_bank_dec #(
  parameter int NBANK = 2,
  parameter int BW    = 1
) (
  input  logic [BW-1:0]    hi,
  output logic [NBANK-1:0] en_n
);
  for (genvar k = 0; k < NBANK; k++) begin : g_en
    assign en_n[k] = (int'(hi) != k);
  end
endmodule

// File: rtl/wsh_merge.sv
// Resolves the shared output lines. Disabled slices drive zero, so an OR is enough.
module wsh_merge #(
  parameter int W     = 8,
  parameter int NBANK = 2
) (
  input  logic [NBANK*W-1:0] bus_in,
  output logic [W-1:0]       y
);
  always_comb begin
    y = '0;
    for (int k = 0; k < NBANK; k++) y = y | bus_in[k*W +: W];
  end
endmodule

// File: rtl/wshift_top.sv
module wshift_top #(
  parameter int SLICE_W = 4,
  parameter int N_SLICE = 2,
  parameter int N_BANK  = 2,
  localparam int WIDTH  = SLICE_W * N_SLICE,
  localparam int SELW   = $clog2(SLICE_W),
  localparam int BW     = $clog2(N_BANK),
  localparam int AW     = SELW + BW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic [AW-1:0]    amt,
  input  logic [1:0]       mode,
  output logic [WIDTH-1:0] dout
);
  localparam int XW = N_BANK * SLICE_W - 1;
  localparam int WINW = 2 * SLICE_W - 1;

  logic [WIDTH+XW-1:0]       ext;
  logic [N_BANK-1:0]         bank_en_n;
  logic [N_BANK*WIDTH-1:0]   bank_out;
  logic [N_BANK*N_SLICE-1:0] slice_drv;
  logic [N_BANK-1:0]         bank_drv;
  logic [WIDTH-1:0]          merged;

  wsh_fill #(.W(WIDTH), .XW(XW)) u_fill (
    .d(din), .mode(wsh_pkg::fill_e'(mode)), .ext(ext)
  );

  wsh_bank_dec #(.NBANK(N_BANK), .BW(BW)) u_dec (
    .hi(amt[AW-1:SELW]), .en_n(bank_en_n)
  );

  for (genvar k = 0; k < N_BANK; k++) begin : g_bank
    for (genvar b = 0; b < N_SLICE; b++) begin : g_slice
      wsh_slice #(.SW(SLICE_W), .SELW(SELW)) u_slice (
        .win (ext[(b + k) * SLICE_W +: WINW]),
        .sel (amt[SELW-1:0]),
        .en_n(bank_en_n[k]),
        .o   (bank_out[k*WIDTH + b*SLICE_W +: SLICE_W]),
        .drv (slice_drv[k*N_SLICE + b])
      );
    end
    assign bank_drv[k] = slice_drv[k*N_SLICE];
  end

  wsh_merge #(.W(WIDTH), .NBANK(N_BANK)) u_merge (
    .bus_in(bank_out), .y(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= merged;
  end

  assert_one_bank_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot(bank_drv));
  assert_bank_pick_R3: assert property (@(posedge clk) disable iff (rst)
    bank_drv[amt[AW-1:SELW]]);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (dout == '0));
  assert_zero_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (amt == '0) |=> (dout == $past(din)));
  assert_sign_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> (dout[WIDTH-1] == $past(din[WIDTH-1])));
  assert_zero_top_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && amt != '0) |=> (dout[WIDTH-1] == 1'b0));
  assert_rot_count_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |=> ($countones(dout) == $countones($past(din))));
endmodule

// File: tb/wshift_top_tb.sv
module wshift_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = '0;
  logic [2:0] amt = '0;
  logic [1:0] mode = '0;
  logic [7:0] dout;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wshift_top u_dut (.clk(clk), .rst(rst), .din(din), .amt(amt), .mode(mode), .dout(dout));

  function automatic logic [7:0] ref_shift(logic [7:0] d, int a, int m);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) begin
      int idx = j + a;
      if (idx < 8)     r[j] = d[idx];
      else if (m == 2) r[j] = d[idx-8];
      else if (m == 1) r[j] = d[7];
      else             r[j] = 1'b0;
    end
    return r;
  endfunction

  function automatic string tag_of(int a, int m);
    if (a == 0) return "R2";
    if (m == 1) return "R6";
    if (m == 2) return "R7";
    if (m == 3) return "R8";
    if (a >= 4) return "R3";
    return "R5";
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: dout=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [7:0] d, int a, int m, string req);
    @(negedge clk);
    din = d; amt = 3'(a); mode = 2'(m);
    @(negedge clk);
    check(req, dout, ref_shift(d, a, m));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: dout=%h expected=done", dout);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unused = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R1", dout, 8'h00);
    rst = 1'b0;
    // R4: direction toward bit 0
    run(8'hF0, 4, 0, "R4");
    run(8'h02, 1, 0, "R4");
    // directed corner words across all amounts and modes
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 8; a++) begin
        run(8'hFF, a, m, tag_of(a, m));
        run(8'h80, a, m, tag_of(a, m));
        run(8'hA5, a, m, tag_of(a, m));
      end
    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [7:0] d = 8'($urandom);
      int a = int'($urandom % 8);
      int m = int'($urandom % 4);
      if (i % 5 == 0) d[7] = 1'b1;
      run(d, a, m, tag_of(a, m));
    end
    // R1 mid-run reset with busy inputs
    @(negedge clk);
    din = 8'hFF; amt = 3'd0; mode = 2'b10; rst = 1'b1;
    @(negedge clk);
    check("R1", dout, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R2", dout, 8'hFF);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule